// File: doc/BRIEF.md
# Multi-PHY Cell Receive Slave Port

This block is the device side of the receive direction on a shared cell bus where one master polls several devices. Each instance buffers whole 52-byte cells. A cell is four header bytes followed by 48 payload bytes. A local write port loads the cells one byte at a time, with a start marker on the first byte. The master places a 5-bit device address on the bus. A polled instance answers one clock later with a cell-available flag.

The master selects an instance by presenting its address while read enable is inactive. Read enable then goes active in a later cycle. The selected instance drives cell bytes and a start-of-cell flag onto the shared 8-bit data bus. A transfer can stop part way through a cell when the master deselects the instance. It resumes at the next byte when the instance is selected again.

When a complete cell becomes ready at the edge where the master drops read enable, the instance still places that cell's first byte on the bus. This is the unexpected-cell case. Every output is a value plus an output-enable, so that a bench can join several instances on one bus.

Top module: `mphy_rx_port`

## Requirements
- R1: A cell leaves the bus as 52 bytes in the order they were loaded. The start-of-cell flag is 1 with the first byte and 0 with the other 51, so it is never high on two consecutive cycles.
- R2: Selection is taken at every clock edge where read enable is sampled inactive (`bus_ren_n_i` = 1). The instance becomes selected when the sampled address equals `DEV_ADDR`, and is deselected otherwise. Address 5'h1F never selects an instance and never enables its cell-available output.
- R3: One clock after the instance samples its own address, `bus_clav_oe_o` is 1 and `bus_clav_n_o` is 0 when a complete or partly sent cell is held, and 1 otherwise. For any other sampled address, `bus_clav_oe_o` is 0.
- R4: After the last byte of a cell, when no further complete cell is held, the data and start-of-cell outputs stay enabled. Start-of-cell stays 0 and the data bus keeps the last byte for as long as read enable stays active.
- R5: At an edge where the selected instance samples read enable inactive right after an active sample, at a cell boundary with a complete cell held, the instance drives that cell's first byte with start-of-cell 1.
- R6: The data and start-of-cell enables are 0 from reset. They fall one clock after read enable is first sampled inactive, so two consecutive inactive samples always leave them 0.
- R7: After reselection, the first byte on an active read enable edge continues the interrupted cell at the next byte, with start-of-cell 0. No byte is repeated or skipped.
- R8: `wr_ready_o` is 1 while fewer than two complete cells are held. It only rises after the last byte of a cell has left on the bus. Bytes offered while it is 0 are ignored.
- R9: On a bus shared by instances with different addresses, no two instances enable their data outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and write port |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid_i | input | 1 | Write-port byte offered |
| wr_sop_i | input | 1 | Offered byte is the first of a cell |
| wr_data_i | input | 8 | Write-port byte |
| wr_ready_o | output | 1 | Room for another cell |
| bus_addr_i | input | 5 | Polling and selection address |
| bus_ren_n_i | input | 1 | Read enable, active low |
| bus_data_o | output | 8 | Cell byte to the shared bus |
| bus_data_oe_o | output | 1 | Enable for `bus_data_o` |
| bus_soc_o | output | 1 | Start-of-cell flag |
| bus_soc_oe_o | output | 1 | Enable for `bus_soc_o` |
| bus_clav_n_o | output | 1 | Cell available, active low |
| bus_clav_oe_o | output | 1 | Enable for `bus_clav_n_o` |

## Verification
The assertions check, on every cycle:
- that the outputs are released after two inactive read-enable samples;
- that the outputs are never driven without a recent active read enable;
- that start-of-cell never appears on two cycles in a row;
- that the cell-available output is enabled only after the instance's own address;
- that the write port only regains room when a cell has finished on the bus.

Only the bench scenarios show the rest: byte order across a pause and reselection, the first header byte in the unexpected-cell case, the hold after the last byte when nothing is ready, and the absence of contention between three instances on one bus.

// File: rtl/mphy_rx_pkg.sv
// Shared constants for the multi-device cell receive port.
// Assumes one byte-wide bus lane and a 5-bit device address space.
package mphy_rx_pkg;
    localparam int unsigned CELL_LEN_DEF  = 52;
    localparam int unsigned CELL_SLOT_DEF = 2;
    localparam int unsigned BUS_DW_DEF    = 8;
    localparam int unsigned BUS_AW_DEF    = 5;
endpackage

// File: rtl/mphy_rx_cellbuf.sv
// Cell store: a ring of SLOTS cell-sized slots.
// The write side fills one slot per cell. A start marker restarts the slot, and a
// byte with no marker and no cell open is dropped. The read side walks one slot
// byte by byte. A slot counts as held from its commit until its last byte is read.
// Assumes rd_adv_i is only raised when a cell is held.
module mphy_rx_cellbuf #(
    parameter int unsigned CELL_BYTES = 52,
    parameter int unsigned SLOTS      = 2,
    parameter int unsigned DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid_i,
    input  logic          wr_sop_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_ready_o,
    input  logic          rd_adv_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_first_o,
    output logic          rd_last_o,
    output logic          cell_avail_o
);
    localparam int unsigned POS_W  = $clog2(CELL_BYTES);
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
    localparam int unsigned DEPTH  = SLOTS * CELL_BYTES;
    localparam int unsigned MEM_AW = $clog2(DEPTH);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

    logic [DW-1:0]     mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [POS_W-1:0]  wr_pos, rd_pos;
    logic              wr_open;
    logic [CNT_W-1:0]  held_cnt;
    logic              accept, commit, rd_done;
    logic [POS_W-1:0]  wr_idx;

    function automatic logic [SLOT_W-1:0] slot_step(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + SLOT_W'(1);
    endfunction

    function automatic logic [MEM_AW-1:0] flat(input logic [SLOT_W-1:0] s,
                                               input logic [POS_W-1:0] p);
        return MEM_AW'(s) * MEM_AW'(CELL_BYTES) + MEM_AW'(p);
    endfunction

    assign wr_ready_o   = (held_cnt < CNT_W'(SLOTS));
    assign accept       = wr_valid_i && wr_ready_o;
    assign commit       = accept && wr_open && !wr_sop_i && (wr_pos == LAST_POS);
    assign wr_idx       = wr_sop_i ? '0 : wr_pos;
    assign rd_last_o    = (rd_pos == LAST_POS);
    assign rd_first_o   = (rd_pos == '0);
    assign rd_done      = rd_adv_i && rd_last_o;
    assign cell_avail_o = (held_cnt != '0);
    assign rd_data_o    = mem[flat(rd_slot, rd_pos)];

    // Store an accepted byte at its place in the open slot.
    always_ff @(posedge clk) begin
        if (accept && (wr_sop_i || wr_open))
            mem[flat(wr_slot, wr_idx)] <= wr_data_i;
    end

    // Track the write position and move to the next slot when a cell completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            wr_pos  <= '0;
            wr_open <= 1'b0;
        end else if (accept) begin
            if (wr_sop_i) begin
                wr_open <= 1'b1;
                wr_pos  <= POS_W'(1);
            end else if (wr_open) begin
                if (wr_pos == LAST_POS) begin
                    wr_open <= 1'b0;
                    wr_pos  <= '0;
                    wr_slot <= slot_step(wr_slot);
                end else begin
                    wr_pos <= wr_pos + POS_W'(1);
                end
            end
        end
    end

    // Track the read position and move to the next slot after a cell's last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= '0;
            rd_pos  <= '0;
        end else if (rd_adv_i) begin
            if (rd_last_o) begin
                rd_pos  <= '0;
                rd_slot <= slot_step(rd_slot);
            end else begin
                rd_pos <= rd_pos + POS_W'(1);
            end
        end
    end

    // Count the cells held, from commit until fully read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_cnt <= '0;
        else if (commit && !rd_done)
            held_cnt <= held_cnt + CNT_W'(1);
        else if (rd_done && !commit)
            held_cnt <= held_cnt - CNT_W'(1);
    end
endmodule

// File: rtl/mphy_rx_select.sv
// Address decode and selection.
// The selection is latched on every edge where read enable is sampled inactive.
// The drive window spans the cycles of active read enable plus the first inactive
// edge. The all-ones address never matches.
module mphy_rx_select #(
    parameter int unsigned AW = 5,
    parameter logic [AW-1:0] DEV_ADDR = AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          ren_act_i,
    output logic          window_o,
    output logic          clav_en_o
);
    localparam logic [AW-1:0] NULL_ADDR = '1;

    logic sel_q, ren_prev_q, addr_hit;

    assign addr_hit = (addr_i == DEV_ADDR) && (addr_i != NULL_ADDR);
    assign window_o = sel_q && (ren_act_i || ren_prev_q);

    // Latch the selection, the previous read enable and the poll response enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= 1'b0;
            ren_prev_q <= 1'b0;
            clav_en_o  <= 1'b0;
        end else begin
            ren_prev_q <= ren_act_i;
            clav_en_o  <= addr_hit;
            if (!ren_act_i)
                sel_q <= addr_hit;
        end
    end
endmodule

// File: rtl/mphy_rx_drive.sv
// Byte sequencer.
// Inside the drive window, a cell boundary with a held cell emits the first byte
// with start-of-cell, whatever read enable is. Mid-cell bytes advance only on
// active read enable. Otherwise the last byte is held.
// The registered outputs give the one-clock release.
module mphy_rx_drive #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          window_i,
    input  logic          ren_act_i,
    input  logic          rd_first_i,
    input  logic          cell_avail_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_adv_o,
    output logic [DW-1:0] data_o,
    output logic          soc_o,
    output logic          oe_o,
    output logic          clav_o
);
    logic emit_new, emit_cont;

    assign emit_new  = window_i && rd_first_i && cell_avail_i;
    assign emit_cont = window_i && !rd_first_i && ren_act_i;
    assign rd_adv_o  = emit_new || emit_cont;

    // Register the bus byte, the start flag, the enable and the availability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            soc_o  <= 1'b0;
            oe_o   <= 1'b0;
            clav_o <= 1'b0;
        end else begin
            oe_o   <= window_i;
            soc_o  <= emit_new;
            clav_o <= cell_avail_i;
            if (rd_adv_o)
                data_o <= rd_data_i;
        end
    end
endmodule

// File: rtl/mphy_rx_port.sv
// Top of the receive slave port: cell store, selection and byte sequencer.
// The bus pins use active-low read enable and cell-available. Every output has
// its own enable, so several instances can share the bus.
// Assumes DEV_ADDR is not the all-ones address.
module mphy_rx_port
    import mphy_rx_pkg::*;
#(
    parameter int unsigned CELL_BYTES = CELL_LEN_DEF,
    parameter int unsigned SLOTS      = CELL_SLOT_DEF,
    parameter int unsigned DW         = BUS_DW_DEF,
    parameter int unsigned AW         = BUS_AW_DEF,
    parameter logic [AW-1:0] DEV_ADDR = AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid_i,
    input  logic          wr_sop_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_ready_o,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_ren_n_i,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_data_oe_o,
    output logic          bus_soc_o,
    output logic          bus_soc_oe_o,
    output logic          bus_clav_n_o,
    output logic          bus_clav_oe_o
);
    logic          ren_act, window, clav_en, clav_q, oe_q;
    logic          rd_adv, rd_first, rd_last, cell_avail;
    logic [DW-1:0] rd_data;

    assign ren_act       = ~bus_ren_n_i;
    assign bus_data_oe_o = oe_q;
    assign bus_soc_oe_o  = oe_q;
    assign bus_clav_n_o  = ~clav_q;
    assign bus_clav_oe_o = clav_en;

    mphy_rx_cellbuf #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid_i), .wr_sop_i(wr_sop_i), .wr_data_i(wr_data_i),
        .wr_ready_o(wr_ready_o), .rd_adv_i(rd_adv), .rd_data_o(rd_data),
        .rd_first_o(rd_first), .rd_last_o(rd_last), .cell_avail_o(cell_avail)
    );

    mphy_rx_select #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_sel (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .ren_act_i(ren_act),
        .window_o(window), .clav_en_o(clav_en)
    );

    mphy_rx_drive #(.DW(DW)) u_drv (
        .clk(clk), .rst_n(rst_n), .window_i(window), .ren_act_i(ren_act),
        .rd_first_i(rd_first), .cell_avail_i(cell_avail), .rd_data_i(rd_data),
        .rd_adv_o(rd_adv), .data_o(bus_data_o), .soc_o(bus_soc_o),
        .oe_o(oe_q), .clav_o(clav_q)
    );
endmodule

// File: rtl/mphy_rx_port_chk.sv
// Property checker for mphy_rx_port, attached to it with bind.
// It watches the bus pins plus the read-advance and last-byte strobes.
module mphy_rx_port_chk #(
    parameter int unsigned AW = 5,
    parameter logic [AW-1:0] DEV_ADDR = AW'(1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr_i,
    input logic          bus_ren_n_i,
    input logic          bus_data_oe_o,
    input logic          bus_soc_o,
    input logic          bus_clav_oe_o,
    input logic          wr_ready_o,
    input logic          rd_adv,
    input logic          rd_last
);
    // R6
    release_after_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ren_n_i) && $past(bus_ren_n_i, 2)) |-> !bus_data_oe_o);

    // R2
    drive_needs_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe_o |-> (!$past(bus_ren_n_i) || !$past(bus_ren_n_i, 2)));

    // R1
    single_soc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_soc_o |=> !bus_soc_o);

    // R3
    clav_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clav_oe_o |-> ($past(bus_addr_i) == DEV_ADDR));

    // R2
    null_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_addr_i) == '1) |-> !bus_clav_oe_o);

    // R8
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ready_o) |-> $past(rd_adv && rd_last));
endmodule

bind mphy_rx_port mphy_rx_port_chk #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_ren_n_i(bus_ren_n_i),
    .bus_data_oe_o(bus_data_oe_o), .bus_soc_o(bus_soc_o),
    .bus_clav_oe_o(bus_clav_oe_o), .wr_ready_o(wr_ready_o),
    .rd_adv(rd_adv), .rd_last(rd_last)
);

// File: tb/mphy_rx_port_tb.sv
// Bench: three instances at addresses 1, 2 and 3 on one bus.
// A behavioural model compares every output on every cycle, and scenario
// checks cover the corner cases.
module mphy_rx_port_tb;
    localparam int ND = 3;
    localparam int CL = 52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ba = 5'h1F;
    logic       bren = 1'b1;
    logic       wv [ND];
    logic       wsop [ND];
    logic [7:0] wd [ND];
    logic       wrdy [ND];
    logic [7:0] dq [ND];
    logic       doe [ND];
    logic       soc [ND];
    logic       soe [ND];
    logic       clvn [ND];
    logic       clvoe [ND];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < ND; g++) begin : g_dev
        mphy_rx_port #(.DEV_ADDR(5'(g + 1))) u_dut (
            .clk(clk), .rst_n(rst_n), .wr_valid_i(wv[g]), .wr_sop_i(wsop[g]),
            .wr_data_i(wd[g]), .wr_ready_o(wrdy[g]), .bus_addr_i(ba),
            .bus_ren_n_i(bren), .bus_data_o(dq[g]), .bus_data_oe_o(doe[g]),
            .bus_soc_o(soc[g]), .bus_soc_oe_o(soe[g]), .bus_clav_n_o(clvn[g]),
            .bus_clav_oe_o(clvoe[g])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model state
    logic [7:0] bq [ND][$];
    logic [7:0] wbuf [ND][$];
    int  ncell [ND];
    int  rpos [ND];
    bit  wact [ND];
    bit  msel [ND];
    bit  mpa [ND];
    bit  e_oe [ND];
    bit  e_soc [ND];
    bit  e_coe [ND];
    bit  e_clav [ND];
    logic [7:0] e_data [ND];

    task automatic model_clear();
        for (int d = 0; d < ND; d++) begin
            bq[d].delete(); wbuf[d].delete();
            ncell[d] = 0; rpos[d] = 0; wact[d] = 0; msel[d] = 0; mpa[d] = 0;
            e_oe[d] = 0; e_soc[d] = 0; e_coe[d] = 0; e_clav[d] = 0; e_data[d] = 0;
        end
    endtask

    initial model_clear();

    // Advance the model by one clock edge from the inputs sampled at that edge
    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            for (int d = 0; d < ND; d++) begin
                bit a, win;
                int nc0;
                a = !bren;
                nc0 = ncell[d];
                win = msel[d] && (a || mpa[d]);
                e_clav[d] = (nc0 > 0);
                e_coe[d] = (ba == 5'(d + 1));
                e_oe[d] = win;
                e_soc[d] = 0;
                if (win && rpos[d] == 0 && nc0 > 0) begin
                    e_data[d] = bq[d][0];
                    e_soc[d] = 1;
                    rpos[d] = 1;
                end else if (win && rpos[d] != 0 && a) begin
                    e_data[d] = bq[d][rpos[d]];
                    rpos[d]++;
                    if (rpos[d] == CL) begin
                        for (int k = 0; k < CL; k++) void'(bq[d].pop_front());
                        ncell[d]--;
                        rpos[d] = 0;
                    end
                end
                if (wv[d] && nc0 < 2) begin
                    if (wsop[d]) begin
                        wbuf[d].delete();
                        wbuf[d].push_back(wd[d]);
                        wact[d] = 1;
                    end else if (wact[d]) begin
                        wbuf[d].push_back(wd[d]);
                        if (wbuf[d].size() == CL) begin
                            for (int k = 0; k < CL; k++) bq[d].push_back(wbuf[d][k]);
                            wbuf[d].delete();
                            ncell[d]++;
                            wact[d] = 0;
                        end
                    end
                end
                if (!a) msel[d] = (ba == 5'(d + 1));
                mpa[d] = a;
            end
        end
    end

    // Compare every output with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int drivers;
            drivers = 0;
            for (int d = 0; d < ND; d++) begin
                chk(doe[d] == e_oe[d], "R6 data enable", int'(doe[d]), int'(e_oe[d]));
                chk(soe[d] == e_oe[d], "R6 soc enable", int'(soe[d]), int'(e_oe[d]));
                if (e_oe[d]) begin
                    chk(dq[d] == e_data[d], "R1 data byte", int'(dq[d]), int'(e_data[d]));
                    chk(soc[d] == e_soc[d], "R1 start flag", int'(soc[d]), int'(e_soc[d]));
                end
                chk(clvoe[d] == e_coe[d], "R3 clav enable", int'(clvoe[d]), int'(e_coe[d]));
                if (e_coe[d])
                    chk(clvn[d] == !e_clav[d], "R3 clav value", int'(clvn[d]), int'(!e_clav[d]));
                chk(wrdy[d] == (ncell[d] < 2), "R8 write ready", int'(wrdy[d]), int'(ncell[d] < 2));
                if (doe[d]) drivers++;
            end
            chk(drivers <= 1, "R9 bus contention", drivers, 1);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic [4:0] a, input logic rn);
        ba = a;
        bren = rn;
        step();
    endtask

    task automatic load(input int d, input int cid);
        for (int p = 0; p < CL; p++) begin
            wv[d] = 1'b1;
            wsop[d] = (p == 0);
            wd[d] = {2'(cid), 6'(p)};
            step();
        end
        wv[d] = 1'b0;
        wsop[d] = 1'b0;
    endtask

    function automatic int cb(input int cid, input int p);
        return cid * 64 + p;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < ND; d++) begin
            wv[d] = 1'b0; wsop[d] = 1'b0; wd[d] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R6 R8: reset state
        for (int d = 0; d < ND; d++) begin
            chk(doe[d] == 0, "R6 reset enable", int'(doe[d]), 0);
            chk(clvoe[d] == 0, "R3 reset clav enable", int'(clvoe[d]), 0);
            chk(wrdy[d] == 1, "R8 reset ready", int'(wrdy[d]), 1);
        end

        load(0, 0);
        load(1, 1);

        // R3: polling
        bus(5'd1, 1'b1);
        chk(clvoe[0] == 1 && clvn[0] == 0, "R3 poll dev1 has cell", int'(clvn[0]), 0);
        bus(5'd3, 1'b1);
        chk(clvoe[2] == 1 && clvn[2] == 1, "R3 poll dev3 empty", int'(clvn[2]), 1);
        bus(5'h1F, 1'b1);
        chk(!clvoe[0] && !clvoe[1] && !clvoe[2], "R2 null address poll", int'(clvoe[0]), 0);

        // R1: select dev1 and read its cell
        bus(5'd1, 1'b1);
        bus(5'h1F, 1'b0);
        chk(soc[0] == 1 && dq[0] == 8'(cb(0, 0)), "R1 first byte", int'(dq[0]), cb(0, 0));
        for (int k = 1; k < CL; k++) bus(5'h1F, 1'b0);
        chk(dq[0] == 8'(cb(0, 51)) && soc[0] == 0, "R1 last byte", int'(dq[0]), cb(0, 51));

        // R4: no further cell, read enable held
        for (int k = 0; k < 5; k++) bus(5'h1F, 1'b0);
        chk(doe[0] == 1 && soc[0] == 0 && dq[0] == 8'(cb(0, 51)), "R4 hold after cell",
            int'(dq[0]), cb(0, 51));

        // R5: a cell completes just before read enable drops
        load(0, 2);
        bus(5'h1F, 1'b1);
        chk(doe[0] == 1 && soc[0] == 1 && dq[0] == 8'(cb(2, 0)), "R5 unexpected cell",
            int'(dq[0]), cb(2, 0));
        bus(5'h1F, 1'b1);
        chk(doe[0] == 0, "R6 release", int'(doe[0]), 0);

        // Partial read of dev2, then switch to dev1
        bus(5'd2, 1'b1);
        for (int k = 0; k < 20; k++) bus(5'h1F, 1'b0);
        chk(dq[1] == 8'(cb(1, 19)), "R1 dev2 partial", int'(dq[1]), cb(1, 19));
        bus(5'd1, 1'b1);
        bus(5'h1F, 1'b0);
        chk(doe[1] == 0, "R6 dev2 released", int'(doe[1]), 0);
        chk(soc[0] == 0 && dq[0] == 8'(cb(2, 1)), "R7 dev1 resumes", int'(dq[0]), cb(2, 1));
        for (int k = 2; k < CL; k++) bus(5'h1F, 1'b0);
        chk(dq[0] == 8'(cb(2, 51)), "R7 dev1 completes", int'(dq[0]), cb(2, 51));

        // R7: reselect dev2 and finish its cell
        bus(5'h1F, 1'b1);
        bus(5'd2, 1'b1);
        bus(5'h1F, 1'b0);
        chk(soc[1] == 0 && dq[1] == 8'(cb(1, 20)), "R7 dev2 resumes", int'(dq[1]), cb(1, 20));
        for (int k = 21; k < CL; k++) bus(5'h1F, 1'b0);
        chk(dq[1] == 8'(cb(1, 51)), "R7 dev2 completes", int'(dq[1]), cb(1, 51));

        // R2: null address selects nobody
        bus(5'h1F, 1'b1);
        bus(5'h1F, 1'b1);
        for (int k = 0; k < 3; k++) begin
            bus(5'h1F, 1'b0);
            chk(!doe[0] && !doe[1] && !doe[2], "R2 null selection", int'(doe[0] | doe[1] | doe[2]), 0);
        end

        // R8: fill dev3, offer a third cell while full
        bus(5'h1F, 1'b1);
        load(2, 0);
        load(2, 1);
        chk(wrdy[2] == 0, "R8 full", int'(wrdy[2]), 0);
        load(2, 3);
        chk(wrdy[2] == 0, "R8 still full", int'(wrdy[2]), 0);

        // R1: back-to-back cells with read enable held
        bus(5'd3, 1'b1);
        for (int k = 0; k < CL; k++) bus(5'h1F, 1'b0);
        chk(dq[2] == 8'(cb(0, 51)), "R1 dev3 first cell end", int'(dq[2]), cb(0, 51));
        bus(5'h1F, 1'b0);
        chk(soc[2] == 1 && dq[2] == 8'(cb(1, 0)), "R1 dev3 second cell", int'(dq[2]), cb(1, 0));
        for (int k = 1; k < CL + 3; k++) bus(5'h1F, 1'b0);
        chk(dq[2] == 8'(cb(1, 51)) && soc[2] == 0, "R8 ignored cell absent", int'(dq[2]), cb(1, 51));
        bus(5'h1F, 1'b1);
        bus(5'd3, 1'b1);
        chk(clvoe[2] == 1 && clvn[2] == 1, "R3 dev3 empty", int'(clvn[2]), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule